// File: doc/BRIEF.md
# Wishbone Classic Slave with Rotating Wait States

This block is a synthesizable Wishbone classic slave. It is meant to sit under a master that is being verified, so that the master sees many different response latencies within one run. The slave holds a small array of registers that it reads and writes. Each transfer it terminates waits a number of extra cycles. That number steps through 0, 1, 2, ... up to a configurable limit and then starts again at 0. Over a few transfers, both non-waited and waited terminations therefore occur.

A two-bit configuration input selects how the slave ends each transfer: with an acknowledge, with an error or with a retry. Only acknowledged writes change the register array. Reads present the addressed register on the data output during the acknowledge cycle. All three termination outputs are registered. Even a zero-wait transfer therefore answers one clock after the slave first samples the strobe.

Top module: `wb_waitstate_slave`

## Requirements
- R1: While `rst_i` is high, `ack_o`, `err_o` and `rty_o` are low from the next clock onward, whatever the bus inputs do. The wait rotation restarts at 0 after reset.
- R2: A transfer is only recognised on a rising edge where both `cyc_i` and `stb_i` are high. With `cyc_i` low, a high `stb_i` produces no termination and does not advance the rotation.
- R3: At most one of `ack_o`, `err_o` and `rty_o` is high in any cycle.
- R4: With the wait value w, the termination is high during the cycle after the (w+1)-th consecutive rising edge that sees `cyc_i` and `stb_i` high. The first edge is the one that starts the transfer. Cycles before that show no termination. The first transfer after reset uses w = 0.
- R5: Every termination lasts exactly one clock. When `stb_i` stays high into the next transfer, the cycle after a termination is quiet, and the next transfer starts on the edge after that.
- R6: `cfg_kind_i` selects the response: 0 gives `ack_o`, 1 gives `err_o`, 2 gives `rty_o`, and 3 gives `ack_o`.
- R7: A write changes the register array only when it is acknowledged. Byte lane b (bits 8b+7..8b) is written only if `sel_i[b]` is high. Writes ended with an error or a retry change nothing.
- R8: For an acknowledged read, `dat_o` holds the addressed register during the cycle in which `ack_o` is high.
- R9: If `cyc_i` or `stb_i` drops before the termination is issued, the transfer is dropped. It gets no termination and no write, and the next transfer uses the same wait value.
- R10: The register index is `adr_i[OFF_W+IDX_W-1:OFF_W]`, which is bits 5..2 by default. The byte offset bits and the bits above the index are ignored.
- R11: After each issued termination, the wait value advances by one. If the value just used was at or above `cfg_wait_max_i`, it returns to 0 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Byte address |
| dat_i | input | DATA_W | Write data |
| sel_i | input | DATA_W/8 | Byte lane enables |
| dat_o | output | DATA_W | Read data, valid while `ack_o` is high on a read |
| ack_o | output | 1 | Normal termination |
| err_o | output | 1 | Error termination |
| rty_o | output | 1 | Retry termination |
| cfg_kind_i | input | 2 | Termination kind selector |
| cfg_wait_max_i | input | WAIT_W | Largest wait value before the rotation wraps |

## Verification
The bench predicts the exact cycle of every termination from its own count of the rotation. A slave that is off by one on the wait count, or that answers on the quiet cycle between back-to-back transfers, is caught in the first few transfers. Strobes that are dropped part-way through a transfer are followed by a read-back and a timed transfer. An implementation that writes early, or that advances the rotation on a dropped transfer, shows stale data or a shifted latency. Error and retry writes are read back to catch a register file that ignores the termination kind. Aliased addresses and partial byte enables catch wrong index decoding and lane mixing. A reset in the middle of a wait must restart the rotation at zero.

// File: rtl/wbws_pkg.sv
package wbws_pkg;

  typedef enum logic [1:0] {
    KIND_ACK     = 2'd0,
    KIND_ERR     = 2'd1,
    KIND_RTY     = 2'd2,
    KIND_ACK_ALT = 2'd3
  } term_kind_e;

  function automatic logic kind_is_ack(input term_kind_e k);
    return (k == KIND_ACK) || (k == KIND_ACK_ALT);
  endfunction

endpackage

// File: rtl/wbws_wait_rotor.sv
module wbws_wait_rotor #(
  parameter int WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              advance_i,
  input  logic [WAIT_W-1:0] limit_i,
  output logic [WAIT_W-1:0] wait_o
);

  logic [WAIT_W-1:0] cur_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_q <= '0;
    end else if (advance_i) begin
      if (cur_q >= limit_i) cur_q <= '0;
      else                  cur_q <= cur_q + 1'b1;
    end
  end

  assign wait_o = cur_q;

endmodule

// File: rtl/wbws_term_fsm.sv
module wbws_term_fsm
  import wbws_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        kind_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              ack_o,
  output logic              err_o,
  output logic              rty_o,
  output logic              fire_o,
  output logic              wr_en_o,
  output logic              rd_en_o
);

  logic              busy_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              ack_q, err_q, rty_q;
  logic              term_active;
  logic              fire, start;
  term_kind_e        kind;

  assign kind        = term_kind_e'(kind_i);
  assign term_active = ack_q | err_q | rty_q;

  always_comb begin
    fire  = 1'b0;
    start = 1'b0;
    if (req_i && !term_active) begin
      if (busy_q) begin
        fire = (cnt_q == '0);
      end else if (wait_i == '0) begin
        fire = 1'b1;
      end else begin
        start = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      rty_q  <= 1'b0;
    end else begin
      ack_q <= fire && kind_is_ack(kind);
      err_q <= fire && (kind == KIND_ERR);
      rty_q <= fire && (kind == KIND_RTY);
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= wait_i - 1'b1;
      end else if (fire || !req_i) begin
        busy_q <= 1'b0;
      end else if (busy_q && !term_active) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ack_o   = ack_q;
  assign err_o   = err_q;
  assign rty_o   = rty_q;
  assign fire_o  = fire;
  assign wr_en_o = fire && we_i && kind_is_ack(kind);
  assign rd_en_o = fire && !we_i;

  assert_quiet_in_reset_R1: assert property (@(posedge clk_i)
    rst_i |=> !(ack_q || err_q || rty_q));

  assert_term_needs_request_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_q || err_q || rty_q) |-> $past(req_i));

  assert_single_kind_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({ack_q, err_q, rty_q}));

  assert_one_clock_pulse_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_q || err_q || rty_q) |=> !(ack_q || err_q || rty_q));

endmodule

// File: rtl/wbws_regfile.sv
module wbws_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                clk_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] sel_i,
  output logic [DATA_W-1:0]   rdata_o
);

  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << IDX_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wr_en_i && sel_i[l]) mem[idx_i] <= wdata_i[8*l +: 8];
      if (rd_en_i)             rd_q       <= mem[idx_i];
    end

    assign rdata_o[8*l +: 8] = rd_q;
  end

endmodule

// File: rtl/wb_waitstate_slave.sv
module wb_waitstate_slave #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int WAIT_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                cyc_i,
  input  logic                stb_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   adr_i,
  input  logic [DATA_W-1:0]   dat_i,
  input  logic [DATA_W/8-1:0] sel_i,
  output logic [DATA_W-1:0]   dat_o,
  output logic                ack_o,
  output logic                err_o,
  output logic                rty_o,
  input  logic [1:0]          cfg_kind_i,
  input  logic [WAIT_W-1:0]   cfg_wait_max_i
);

  localparam int SEL_W = DATA_W / 8;
  localparam int OFF_W = (SEL_W > 1) ? $clog2(SEL_W) : 0;

  logic              req;
  logic              fire, wr_en, rd_en;
  logic [WAIT_W-1:0] cur_wait;
  logic [IDX_W-1:0]  idx;
  logic              unused_adr;

  assign req        = cyc_i & stb_i;
  assign idx        = adr_i[OFF_W +: IDX_W];
  assign unused_adr = ^adr_i;

  wbws_wait_rotor #(.WAIT_W(WAIT_W)) rotor_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .advance_i (fire),
    .limit_i   (cfg_wait_max_i),
    .wait_o    (cur_wait)
  );

  wbws_term_fsm #(.WAIT_W(WAIT_W)) fsm_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .req_i   (req),
    .we_i    (we_i),
    .kind_i  (cfg_kind_i),
    .wait_i  (cur_wait),
    .ack_o   (ack_o),
    .err_o   (err_o),
    .rty_o   (rty_o),
    .fire_o  (fire),
    .wr_en_o (wr_en),
    .rd_en_o (rd_en)
  );

  wbws_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) regs_i (
    .clk_i   (clk_i),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .idx_i   (idx),
    .wdata_i (dat_i),
    .sel_i   (sel_i),
    .rdata_o (dat_o)
  );

  assert_write_only_with_ack_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en |=> (ack_o && !err_o && !rty_o));

  assert_dropped_strobe_silent_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!req && !(ack_o || err_o || rty_o)) |=> !(ack_o || err_o || rty_o));

endmodule

// File: tb/wb_waitstate_slave_tb_top.sv
module wb_waitstate_slave_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int WAIT_W = 2;

  logic              clk = 1'b0;
  logic              rst, cyc, stb, we;
  logic [ADDR_W-1:0] adr;
  logic [DATA_W-1:0] wdat, rdat;
  logic [3:0]        sel;
  logic              ack, err, rty;
  logic [1:0]        kind;
  logic [WAIT_W-1:0] wmax;

  always #2 clk = ~clk;

  wb_waitstate_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .WAIT_W(WAIT_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .sel_i(sel), .dat_o(rdat),
    .ack_o(ack), .err_o(err), .rty_o(rty),
    .cfg_kind_i(kind), .cfg_wait_max_i(wmax)
  );

  int checks = 0;
  int fails  = 0;
  int mwait  = 0;
  int mmax   = 3;
  bit prev_keep = 0;
  logic [31:0] mmem [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk({ack, err, rty} == 3'b000, req, "no termination expected",
        {29'd0, ack, err, rty}, 32'd0);
  endtask

  // One transfer; sampled at negedges, driven at negedges.
  task automatic xfer(input bit w_e, input logic [15:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic [1:0] k, input bit keep,
                      input string req);
    int w;
    logic [2:0]  exp3;
    logic [31:0] expr;
    logic [3:0]  ix;
    kind = k; cyc = 1; stb = 1; we = w_e; adr = a; wdat = d; sel = s;
    if (prev_keep) begin
      @(negedge clk);
      quiet("R5");
    end
    w    = mwait;
    ix   = a[5:2];
    expr = mmem[ix];
    exp3 = (k == 2'd1) ? 3'b010 : (k == 2'd2) ? 3'b001 : 3'b100;
    for (int c = 1; c <= w + 1; c++) begin
      @(negedge clk);
      if (c <= w) quiet(req);
      else begin
        chk({ack, err, rty} == exp3, req, "termination kind/timing (ack,err,rty)",
            {29'd0, ack, err, rty}, {29'd0, exp3});
        if (exp3 == 3'b100 && !w_e)
          chk(rdat == expr, "R8", "read data", rdat, expr);
      end
    end
    if (exp3 == 3'b100 && w_e)
      for (int b = 0; b < 4; b++) if (s[b]) mmem[ix][8*b +: 8] = d[8*b +: 8];
    mwait = (mwait >= mmax) ? 0 : mwait + 1;
    prev_keep = keep;
    if (!keep) begin
      cyc = 0; stb = 0; we = 0;
      @(negedge clk);
      quiet("R5");
    end
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    xfer(1'b0, a, 32'h0, 4'hf, 2'd0, 1'b0, req);
  endtask

  initial begin
    #200us;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1; cyc = 1; stb = 1; we = 0; adr = '0; wdat = '0; sel = '0;
    kind = 2'd0; wmax = 2'd3;
    for (int i = 0; i < 3; i++) begin @(negedge clk); quiet("R1"); end
    cyc = 0; stb = 0;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    quiet("R1");

    // fill the array; latency rotates 0,1,2,3,0,... (R4, R11)
    for (int i = 0; i < 16; i++)
      xfer(1'b1, 16'(i * 4), 32'hA5000000 | 32'(i * 32'h10101), 4'hf, 2'd0, 1'b0, "R4");
    for (int i = 0; i < 16; i += 3) rd(16'(i * 4), "R8");

    // byte lanes (R7)
    xfer(1'b1, 16'h0008, 32'h11223344, 4'b0101, 2'd0, 1'b0, "R7");
    rd(16'h0008, "R7");
    xfer(1'b1, 16'h000C, 32'hDEADBEEF, 4'b1000, 2'd0, 1'b0, "R7");
    rd(16'h000C, "R7");

    // index decoding: offset and upper bits ignored (R10)
    xfer(1'b1, 16'hFFD7, 32'hCAFEF00D, 4'hf, 2'd0, 1'b0, "R10");
    rd(16'h0014, "R10");
    rd(16'h4016, "R10");

    // strobe without cycle (R2)
    cyc = 0; stb = 1; we = 1; adr = 16'h0; wdat = 32'h0; sel = 4'hf;
    for (int i = 0; i < 3; i++) begin @(negedge clk); quiet("R2"); end
    stb = 0; we = 0;
    rd(16'h0000, "R2");

    // error and retry terminations, no write (R6, R7)
    xfer(1'b1, 16'h0004, 32'h0BADBAD0, 4'hf, 2'd1, 1'b0, "R6");
    xfer(1'b1, 16'h0004, 32'h0BADBAD1, 4'hf, 2'd2, 1'b0, "R6");
    xfer(1'b0, 16'h0004, 32'h0, 4'hf, 2'd1, 1'b0, "R6");
    rd(16'h0004, "R7");
    xfer(1'b1, 16'h0004, 32'h13572468, 4'hf, 2'd3, 1'b0, "R6");
    rd(16'h0004, "R6");

    // back-to-back with strobe held (R5)
    for (int i = 0; i < 5; i++)
      xfer(1'b1, 16'(16'h0020 + i * 4), 32'(32'h77000000 + i), 4'hf, 2'd0, i != 4, "R5");
    for (int i = 0; i < 5; i++)
      xfer(1'b0, 16'(16'h0020 + i * 4), 32'h0, 4'hf, 2'd0, i != 4, "R5");

    // dropped transfer (R9)
    if (mwait == 0) rd(16'h0000, "R9");
    kind = 2'd0; cyc = 1; stb = 1; we = 1; adr = 16'h0030; wdat = 32'hFFFFFFFF; sel = 4'hf;
    @(negedge clk); quiet("R9");
    cyc = 0; stb = 0; we = 0;
    @(negedge clk); quiet("R9");
    @(negedge clk); quiet("R9");
    rd(16'h0030, "R9");

    // smaller limit (R11)
    wmax = 2'd1; mmax = 1;
    for (int i = 0; i < 5; i++) rd(16'(i * 4), "R11");
    wmax = 2'd0; mmax = 0;
    for (int i = 0; i < 3; i++) rd(16'(i * 4), "R11");
    wmax = 2'd3; mmax = 3;
    rd(16'h0000, "R11");
    rd(16'h0000, "R11");

    // reset in the middle of a wait (R1)
    if (mwait == 0) rd(16'h0000, "R1");
    cyc = 1; stb = 1; we = 0; adr = 16'h0;
    @(negedge clk); quiet("R1");
    rst = 1; cyc = 0; stb = 0;
    @(negedge clk); quiet("R1");
    @(negedge clk); quiet("R1");
    rst = 0; mwait = 0;
    @(negedge clk);
    rd(16'h0004, "R1");
    rd(16'h0008, "R4");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule